// File: doc/BRIEF.md
# Two-Lane Serial Sample Deserializer

This block turns two serial lanes from a 16-bit data converter back into parallel samples. Each lane carries half of every sample. The first bit of each word is marked by a rising edge on a frame signal that runs in the bit-clock domain. The pad stage has already captured each lane on both bit-clock edges and hands over the rising-edge bit and the falling-edge bit as plain single-ended signals. In single data rate mode only the rising-edge bit is used, so a lane delivers one bit per cycle. In double data rate mode both bits are used, and the rising-edge bit is the earlier of the two.

A rate select and a lane-mapping select are sampled only in the cycle that carries a frame rising edge. They then hold for the rest of that word. Each word goes out as a registered 16-bit value with a one-cycle valid pulse. The source is a free-running converter and cannot be stalled, so there is no ready input and no back-pressure. Downstream logic must accept every valid pulse in the cycle it occurs.

A frame edge can arrive while a word is only partly received. When that happens the partial bits are dropped, a one-cycle alignment-error pulse is raised, and reception restarts from that edge.

Top module: `adc_lane_deser`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `out_valid` and `align_err` are 0 and `out_data` is 0.
- R2: With `byte_sel`=0 (bitwise mapping), lane 0 carries sample bits 14,12,…,2,0 and lane 1 carries bits 15,13,…,3,1, each most significant first. Bit k of lane 0's 8-bit word is sample bit 2k, and bit k of lane 1's word is sample bit 2k+1.
- R3: With `byte_sel`=1 (bytewise mapping), lane 0 carries sample bits 7 down to 0 and lane 1 carries bits 15 down to 8, each most significant first.
- R4: With `ddr_sel`=0, a word takes 8 cycles, starting with the cycle in which `frame_in` rises. `out_valid` is high for exactly the one cycle after the 8th bit cycle, and `out_data` holds the sample in that cycle.
- R5: With `ddr_sel`=1, a word takes 4 cycles, and each cycle delivers the rising-edge bit followed by the falling-edge bit of each lane. `out_valid` is a single-cycle pulse in the cycle after the 4th bit cycle. Valid pulses are never back to back.
- R6: A `frame_in` rising edge that arrives while a word is partly received raises `align_err` for one cycle, in the cycle after that edge. The partial word produces no valid. The edge starts a new word, and that word is assembled correctly.
- R7: Changes on `ddr_sel` or `byte_sel` after the first cycle of a word have no effect on that word's length or mapping. They take effect at the next frame edge.
- R8: Lane bits that arrive when no word is in progress, meaning after a word has completed and before the next frame edge, are ignored and produce no valid pulse. In single data rate mode, the falling-edge bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rise_bits | input | 2 | Lane bits captured on the rising edge; index = lane |
| fall_bits | input | 2 | Lane bits captured on the falling edge; index = lane |
| frame_in | input | 1 | Frame marker; a rising edge marks the first bit cycle of a word |
| ddr_sel | input | 1 | 1 = double data rate, 0 = single data rate |
| byte_sel | input | 1 | 1 = bytewise lane mapping, 0 = bitwise lane mapping |
| out_valid | output | 1 | One-cycle strobe for `out_data` |
| out_data | output | 16 | Reassembled sample |
| align_err | output | 1 | One-cycle pulse when a frame edge cuts a word short |

## Verification
A sample is due in the cycle right after the posedge that captures its last bit cycle. That is one cycle after the 8th bit cycle in single data rate mode and one cycle after the 4th in double data rate mode. An alignment error is due one cycle after the frame edge that interrupts a word. The driver stamps every expected sample and error with the cycle number at which it must appear. The monitor samples at the falling edge and compares both the value and the cycle stamp, so a result that comes early or late fails even when its value is right. The sender model delays its converter samples by a 16-frame pipeline, so the first 16 words of a stream are zero.

// File: rtl/adc_deser_pkg.sv
package adc_deser_pkg;
  localparam int unsigned SAMPLE_W  = 16;
  localparam int unsigned NUM_LANES = 2;
  localparam int unsigned LANE_W    = SAMPLE_W / NUM_LANES;

  typedef enum logic {
    MAP_BITWISE  = 1'b0,
    MAP_BYTEWISE = 1'b1
  } lane_map_e;

  typedef enum logic {
    RATE_SDR = 1'b0,
    RATE_DDR = 1'b1
  } bit_rate_e;
endpackage

// File: rtl/adc_frame_align.sv
module adc_frame_align #(
  parameter int unsigned LANE_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_in,
  input  logic ddr_sel,
  input  logic byte_sel,
  output logic shift_en,
  output logic eff_ddr,
  output logic eff_byte,
  output logic word_done,
  output logic frame_err
);
  localparam int unsigned CW = $clog2(LANE_W + 1);
  localparam logic [CW-1:0] BEATS_SDR = CW'(LANE_W);
  localparam logic [CW-1:0] BEATS_DDR = CW'(LANE_W / 2);

  logic          frame_q;
  logic [CW-1:0] cnt, cnt_inc, cnt_nxt, beats;
  logic          cur_ddr, cur_byte;
  logic          fr_edge;

  assign fr_edge  = frame_in & ~frame_q;
  assign eff_ddr  = fr_edge ? ddr_sel  : cur_ddr;
  assign eff_byte = fr_edge ? byte_sel : cur_byte;
  assign beats    = eff_ddr ? BEATS_DDR : BEATS_SDR;
  assign shift_en = fr_edge | (cnt != '0);
  assign cnt_inc  = fr_edge ? CW'(1) : CW'(cnt + 1'b1);
  assign word_done = shift_en && (cnt_inc == beats);
  assign frame_err = fr_edge && (cnt != '0);

  always_comb begin
    if (!shift_en || word_done) cnt_nxt = '0;
    else                        cnt_nxt = cnt_inc;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frame_q  <= 1'b0;
      cnt      <= '0;
      cur_ddr  <= 1'b0;
      cur_byte <= 1'b0;
    end else begin
      frame_q <= frame_in;
      cnt     <= cnt_nxt;
      if (fr_edge) begin
        cur_ddr  <= ddr_sel;
        cur_byte <= byte_sel;
      end
    end
  end

  // R4
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < BEATS_SDR);
endmodule

// File: rtl/adc_lane_shifter.sv
module adc_lane_shifter #(
  parameter int unsigned LANE_W    = 8,
  parameter int unsigned NUM_LANES = 2
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               shift_en,
  input  logic                               ddr,
  input  logic [NUM_LANES-1:0]               rise_bits,
  input  logic [NUM_LANES-1:0]               fall_bits,
  output logic [NUM_LANES-1:0][LANE_W-1:0]   lane_next
);
  logic [NUM_LANES-1:0][LANE_W-1:0] lane_q;

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    always_comb begin
      if (!shift_en)  lane_next[l] = lane_q[l];
      else if (ddr)   lane_next[l] = {lane_q[l][LANE_W-3:0], rise_bits[l], fall_bits[l]};
      else            lane_next[l] = {lane_q[l][LANE_W-2:0], rise_bits[l]};
    end

    always_ff @(posedge clk) begin
      if (!rst_n) lane_q[l] <= '0;
      else        lane_q[l] <= lane_next[l];
    end
  end
endmodule

// File: rtl/adc_word_mapper.sv
module adc_word_mapper #(
  parameter int unsigned LANE_W = 8
) (
  input  logic [1:0][LANE_W-1:0] lanes,
  input  logic                   byte_mode,
  output logic [2*LANE_W-1:0]    word
);
  logic [2*LANE_W-1:0] interleaved;

  for (genvar k = 0; k < LANE_W; k++) begin : g_bit
    assign interleaved[2*k]   = lanes[0][k];
    assign interleaved[2*k+1] = lanes[1][k];
  end

  assign word = byte_mode ? {lanes[1], lanes[0]} : interleaved;
endmodule

// File: rtl/adc_lane_deser.sv
module adc_lane_deser
  import adc_deser_pkg::*;
#(
  parameter int unsigned SAMPLE_BITS = SAMPLE_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [1:0]             rise_bits,
  input  logic [1:0]             fall_bits,
  input  logic                   frame_in,
  input  logic                   ddr_sel,
  input  logic                   byte_sel,
  output logic                   out_valid,
  output logic [SAMPLE_BITS-1:0] out_data,
  output logic                   align_err
);
  localparam int unsigned LW = SAMPLE_BITS / 2;

  logic               shift_en, eff_ddr, eff_byte, word_done, frame_err;
  logic [1:0][LW-1:0] lane_next;
  logic [SAMPLE_BITS-1:0] word;

  adc_frame_align #(.LANE_W(LW)) u_align (
    .clk(clk), .rst_n(rst_n), .frame_in(frame_in),
    .ddr_sel(ddr_sel), .byte_sel(byte_sel),
    .shift_en(shift_en), .eff_ddr(eff_ddr), .eff_byte(eff_byte),
    .word_done(word_done), .frame_err(frame_err)
  );

  adc_lane_shifter #(.LANE_W(LW), .NUM_LANES(2)) u_shift (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .ddr(eff_ddr),
    .rise_bits(rise_bits), .fall_bits(fall_bits), .lane_next(lane_next)
  );

  adc_word_mapper #(.LANE_W(LW)) u_map (
    .lanes(lane_next), .byte_mode(eff_byte), .word(word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      align_err <= 1'b0;
    end else begin
      out_valid <= word_done;
      align_err <= frame_err;
      if (word_done) out_data <= word;
    end
  end

  // R5
  no_double_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R6
  err_needs_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    align_err |-> $past(frame_in));

  // R6
  err_valid_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(align_err && out_valid));
endmodule

// File: tb/adc_lane_deser_bench.sv
module adc_lane_deser_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  rise_bits = '0, fall_bits = '0;
  logic        frame_in = 1'b0, ddr_sel = 1'b0, byte_sel = 1'b0;
  logic        out_valid, align_err;
  logic [15:0] out_data;

  int n_chk = 0, n_fail = 0, cyc = 0, frame_no = 0;
  bit abort_pending = 0;
  logic [15:0] exp_data_q[$];
  int          exp_cyc_q[$];
  string       exp_tag_q[$];
  int          err_cyc_q[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  adc_lane_deser u_adc_lane_deser (
    .clk(clk), .rst_n(rst_n), .rise_bits(rise_bits), .fall_bits(fall_bits),
    .frame_in(frame_in), .ddr_sel(ddr_sel), .byte_sel(byte_sel),
    .out_valid(out_valid), .out_data(out_data), .align_err(align_err)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] conv_sample(input int n);
    return 16'(n * 40503 + 4660);
  endfunction

  task automatic send_word(input logic [15:0] d, input bit ddr, input bit bytem,
                           input bit scramble, input string tag);
    logic [7:0] l0, l1;
    int beats;
    if (bytem) begin l0 = d[7:0]; l1 = d[15:8]; end
    else for (int k = 0; k < 8; k++) begin l0[k] = d[2*k]; l1[k] = d[2*k+1]; end
    beats = ddr ? 4 : 8;
    for (int i = 0; i < beats; i++) begin
      @(negedge clk);
      frame_in = (i < beats / 2);
      ddr_sel  = (scramble && i > 0) ? ~ddr : ddr;
      byte_sel = (scramble && i > 0) ? ~bytem : bytem;
      if (ddr) begin
        rise_bits = {l1[7-2*i], l0[7-2*i]};
        fall_bits = {l1[6-2*i], l0[6-2*i]};
      end else begin
        rise_bits = {l1[7-i], l0[7-i]};
        fall_bits = 2'($urandom);
      end
      if (i == 0 && abort_pending) begin
        err_cyc_q.push_back(cyc + 1);
        abort_pending = 0;
      end
    end
    exp_data_q.push_back(d);
    exp_cyc_q.push_back(cyc + 1);
    exp_tag_q.push_back(tag);
  endtask

  task automatic send_partial(input int n, input bit ddr);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      frame_in  = (i == 0);
      ddr_sel   = ddr;
      rise_bits = 2'($urandom);
      fall_bits = 2'($urandom);
    end
    abort_pending = 1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      frame_in  = 1'b0;
      rise_bits = 2'($urandom);
      fall_bits = 2'($urandom);
    end
  endtask

  task automatic stream(input int n, input bit ddr, input bit bytem, input string tag);
    for (int f = 0; f < n; f++) begin
      send_word(frame_no >= 16 ? conv_sample(frame_no - 16) : 16'h0, ddr, bytem, 0, tag);
      frame_no++;
    end
  endtask

  // Monitor: pops expected results and compares value and cycle stamp
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_data_q.size() == 0) check(0, "R8 unexpected valid", cyc, 0);
      else begin
        logic [15:0] ed; int ec; string et;
        ed = exp_data_q.pop_front(); ec = exp_cyc_q.pop_front(); et = exp_tag_q.pop_front();
        check(out_data == ed, et, out_data, ed);
        check(cyc == ec, {et, " valid cycle"}, cyc, ec);
      end
    end
    if (rst_n && align_err) begin
      if (err_cyc_q.size() == 0) check(0, "R6 unexpected align_err", cyc, 0);
      else begin
        int ec;
        ec = err_cyc_q.pop_front();
        check(cyc == ec, "R6 align_err cycle", cyc, ec);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(0, "watchdog", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid == 0 && align_err == 0 && out_data == 0, "R1 reset outputs",
          {out_valid, align_err}, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 0 && out_data == 0, "R1 after reset", out_data, 0);

    // R2 / R4 bitwise SDR directed patterns
    send_word(16'h0001, 0, 0, 0, "R2 bitwise sdr 0001");
    send_word(16'h8000, 0, 0, 0, "R2 bitwise sdr 8000");
    send_word(16'hAAAA, 0, 0, 0, "R4 bitwise sdr AAAA");
    // R3 bytewise
    send_word(16'h5A3C, 0, 1, 0, "R3 bytewise sdr 5A3C");
    send_word(16'h00FF, 1, 1, 0, "R3 bytewise ddr 00FF");
    // R5 DDR bitwise
    send_word(16'h5555, 1, 0, 0, "R5 bitwise ddr 5555");
    send_word(16'hC3A1, 1, 0, 0, "R5 bitwise ddr C3A1");
    // R8 idle bits ignored
    idle(13);
    check(exp_data_q.size() == 0, "R8 idle no pending", exp_data_q.size(), 0);
    // R7 mode flips mid-word
    send_word(16'h1234, 0, 0, 1, "R7 sdr bitwise flipped");
    send_word(16'hBEEF, 1, 1, 1, "R7 ddr bytewise flipped");
    // R6 partial words
    send_partial(3, 0);
    send_word(16'h0F0F, 0, 1, 0, "R6 after sdr abort");
    send_partial(2, 1);
    send_word(16'hF00D, 1, 0, 0, "R6 after ddr abort");
    idle(5);
    // sender model streams with pipeline latency
    stream(24, 0, 0, "R4 stream sdr bitwise");
    stream(24, 1, 1, "R5 stream ddr bytewise");
    stream(8, 1, 0, "R5 stream ddr bitwise");
    idle(6);
    check(exp_data_q.size() == 0, "R4 all samples seen", exp_data_q.size(), 0);
    check(err_cyc_q.size() == 0, "R6 all errors seen", err_cyc_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule